// File: doc/BRIEF.md
# Legacy Peripheral Configuration Port

This block is the configuration front end of a multi-function peripheral controller. It decodes two neighbouring byte addresses on a simple synchronous 8-bit host bus: the lower one holds a register index, the upper one carries data to and from whichever configuration register that index selects. The configuration space stays hidden until the host writes an unlock key to the index address. A separate lock key written to the same address hides it again.

While the port is unlocked, the host can read a fixed chip identification byte and a revision byte. It can also choose one of several logical devices and program that device's 16-bit I/O base address as a high byte and a low byte. Every logical device keeps its own base address. All base addresses are driven out in parallel so that address decoders elsewhere can use them. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the index register holds 0x00, the selected logical device is 0, every base address output is 0x0000 and the read data bus shows 0xFF.
- R2: While locked, a read of either address (offset 0 index, offset 1 data) returns 0xFF.
- R3: While locked, data-address writes change no register, and index-address writes of any value other than 0x55 leave the port locked.
- R4: Writing 0x55 to offset 0 while locked unlocks the port and leaves the index unchanged. Writing 0xAA to offset 0 while unlocked locks it again.
- R5: While unlocked, every offset-0 write other than 0xAA loads the index register, and an offset-0 read returns the index.
- R6: While unlocked, index 0x20 reads the chip ID 0x7A and index 0x21 reads the revision 0x01. Writes to either index have no effect.
- R7: Index 0x07 selects the logical device. A write keeps the low log2(NUM_LD) bits of the data byte, and a read returns those bits zero-extended.
- R8: Index 0x60 reads and writes the high byte, and index 0x61 the low byte, of the selected device's base address only. Device k's base appears on ld_base_flat[16k+15:16k] as {high, low}.
- R9: While unlocked, reads of any other index return 0x00 and writes to them change nothing.
- R10: bus_rdata takes the read value on the clock edge that samples bus_rd and holds it until the next read.
- R11: Locking and unlocking again leave every base address and the device selection as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ld_base_flat | output | NUM_LD*16 | Base addresses of all logical devices, device k in bits 16k+15:16k |

## Verification
The bench sweeps all 256 index-address values while locked. A design that unlocked on a stray key, or on the lock key, would then return something other than 0xFF from the data address. It also sweeps all 256 indexes while unlocked and computes the expected byte for each one. This catches a mux that aliases reserved indexes onto the ID, the revision or the base registers, and any write to a reserved index that leaks into a real register. Each logical device is given a distinct base pattern, so that a wrong bank decode, or a select that ignores its truncation, corrupts a neighbour's output. Finally, a lock and unlock cycle shows whether the banks survive the mode change and whether a locked data write slips through.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   typedef enum logic {
      CFG_LOCKED = 1'b0,
      CFG_OPEN   = 1'b1
   } cfg_mode_e;

   localparam logic [7:0] RD_IDLE_BYTE = 8'hFF;
   localparam logic [7:0] RD_VOID_BYTE = 8'h00;

   localparam logic BUS_OFS_INDEX = 1'b0;
   localparam logic BUS_OFS_DATA  = 1'b1;

endpackage

// File: rtl/sio_cfg_keylock.sv
module sio_cfg_keylock
   import cfgport_pkg::*;
#(
   parameter logic [7:0] KEY_START = 8'h55,
   parameter logic [7:0] KEY_END   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       cfg_open,
   output logic [7:0] idx_q
);

   cfg_mode_e mode_q, mode_d;
   logic [7:0] idx_d;

   always_comb begin
      mode_d = mode_q;
      idx_d  = idx_q;
      if (idx_wr) begin
         if (mode_q == CFG_LOCKED) begin
            if (wdata == KEY_START) mode_d = CFG_OPEN;
         end else if (wdata == KEY_END) begin
            mode_d = CFG_LOCKED;
         end else begin
            idx_d = wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= CFG_LOCKED;
         idx_q  <= 8'h00;
      end else begin
         mode_q <= mode_d;
         idx_q  <= idx_d;
      end
   end

   assign cfg_open = (mode_q == CFG_OPEN);

   p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !cfg_open && wdata == KEY_START) |=> cfg_open);
   p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && cfg_open && wdata == KEY_END) |=> !cfg_open);
   p_stay_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && !(idx_wr && wdata == KEY_START)) |=> (!cfg_open && $stable(idx_q)));
   p_idx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && cfg_open && wdata != KEY_END) |=> (idx_q == $past(wdata)));

endmodule

// File: rtl/sio_cfg_ldbank.sv
module sio_cfg_ldbank #(
   parameter int          NUM_LD    = 8,
   parameter logic [7:0]  IDX_LDSEL = 8'h07,
   parameter logic [7:0]  IDX_BMSB  = 8'h60,
   parameter logic [7:0]  IDX_BLSB  = 8'h61,
   localparam int         LD_W      = $clog2(NUM_LD)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_open,
   input  logic                 dat_wr,
   input  logic [7:0]           idx,
   input  logic [7:0]           wdata,
   output logic [LD_W-1:0]      ld_sel_q,
   output logic [NUM_LD*16-1:0] base_flat
);

   logic               acc_ok;
   logic               sel_we;
   logic [NUM_LD-1:0]  msb_we;
   logic [NUM_LD-1:0]  lsb_we;

   assign acc_ok = cfg_open && dat_wr;
   assign sel_we = acc_ok && (idx == IDX_LDSEL);

   always_ff @(posedge clk) begin
      if (!rst_n)      ld_sel_q <= '0;
      else if (sel_we) ld_sel_q <= wdata[LD_W-1:0];
   end

   for (genvar k = 0; k < NUM_LD; k++) begin : g_dev
      logic [7:0] msb_q;
      logic [7:0] lsb_q;
      logic       hit;

      assign hit       = (ld_sel_q == LD_W'(k));
      assign msb_we[k] = acc_ok && hit && (idx == IDX_BMSB);
      assign lsb_we[k] = acc_ok && hit && (idx == IDX_BLSB);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            msb_q <= 8'h00;
            lsb_q <= 8'h00;
         end else begin
            if (msb_we[k]) msb_q <= wdata;
            if (lsb_we[k]) lsb_q <= wdata;
         end
      end

      assign base_flat[k*16 +: 16] = {msb_q, lsb_q};
   end

   p_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({msb_we, lsb_we}));
   p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> ($stable(base_flat) && $stable(ld_sel_q)));
   p_sel_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (ld_sel_q == $past(wdata[LD_W-1:0])));

endmodule

// File: rtl/sio_cfg_rdpath.sv
module sio_cfg_rdpath
   import cfgport_pkg::*;
#(
   parameter int          LD_W      = 3,
   parameter logic [7:0]  IDX_LDSEL = 8'h07,
   parameter logic [7:0]  IDX_ID    = 8'h20,
   parameter logic [7:0]  IDX_REV   = 8'h21,
   parameter logic [7:0]  IDX_BMSB  = 8'h60,
   parameter logic [7:0]  IDX_BLSB  = 8'h61,
   parameter logic [7:0]  CHIP_ID   = 8'h7A,
   parameter logic [7:0]  CHIP_REV  = 8'h01,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  logic            addr,
   input  logic            cfg_open,
   input  logic [7:0]      idx,
   input  logic [LD_W-1:0] ld_sel,
   input  logic [15:0]     sel_base,
   output logic [7:0]      rdata
);

   logic [7:0] rd_val;

   always_comb begin
      if (!cfg_open)                  rd_val = RD_IDLE_BYTE;
      else if (addr == BUS_OFS_INDEX) rd_val = idx;
      else if (idx == IDX_ID)         rd_val = CHIP_ID;
      else if (idx == IDX_REV)        rd_val = CHIP_REV;
      else if (idx == IDX_LDSEL)      rd_val = {{(8-LD_W){1'b0}}, ld_sel};
      else if (idx == IDX_BMSB)       rd_val = sel_base[15:8];
      else if (idx == IDX_BLSB)       rd_val = sel_base[7:0];
      else                            rd_val = RD_VOID_BYTE;
   end

   if (READ_REG) begin : g_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)  rdata_q <= RD_IDLE_BYTE;
         else if (rd) rdata_q <= rd_val;
      end
      assign rdata = rdata_q;

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd |=> $stable(rdata));
      p_locked_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd && !cfg_open) |=> (rdata == RD_IDLE_BYTE));
   end else begin : g_comb
      assign rdata = rd ? rd_val : RD_IDLE_BYTE;

      always_comb begin
         if (rst_n && rd && !cfg_open)
            p_locked_ff_comb_r2: assert (rdata == RD_IDLE_BYTE);
      end
   end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import cfgport_pkg::*;
#(
   parameter int          NUM_LD    = 8,
   parameter logic [7:0]  KEY_START = 8'h55,
   parameter logic [7:0]  KEY_END   = 8'hAA,
   parameter logic [7:0]  IDX_LDSEL = 8'h07,
   parameter logic [7:0]  IDX_ID    = 8'h20,
   parameter logic [7:0]  IDX_REV   = 8'h21,
   parameter logic [7:0]  IDX_BMSB  = 8'h60,
   parameter logic [7:0]  IDX_BLSB  = 8'h61,
   parameter logic [7:0]  CHIP_ID   = 8'h7A,
   parameter logic [7:0]  CHIP_REV  = 8'h01,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   output logic [NUM_LD*16-1:0] ld_base_flat
);

   localparam int LD_W = $clog2(NUM_LD);

   if (NUM_LD < 2 || NUM_LD > 128 || (1 << LD_W) != NUM_LD) begin : g_bad_num_ld
      $error("NUM_LD must be a power of two between 2 and 128");
   end
   if (KEY_START == KEY_END) begin : g_bad_keys
      $error("start and end keys must differ");
   end
   if (IDX_LDSEL == IDX_ID || IDX_LDSEL == IDX_REV || IDX_LDSEL == IDX_BMSB ||
       IDX_LDSEL == IDX_BLSB || IDX_ID == IDX_REV || IDX_ID == IDX_BMSB ||
       IDX_ID == IDX_BLSB || IDX_REV == IDX_BMSB || IDX_REV == IDX_BLSB ||
       IDX_BMSB == IDX_BLSB) begin : g_bad_idx
      $error("configuration indexes must be distinct");
   end

   logic            cfg_open;
   logic [7:0]      idx_q;
   logic [LD_W-1:0] ld_sel;
   logic [15:0]     sel_base;
   logic            idx_wr;
   logic            dat_wr;

   assign idx_wr = bus_wr && (bus_addr == BUS_OFS_INDEX);
   assign dat_wr = bus_wr && (bus_addr == BUS_OFS_DATA);

   sio_cfg_keylock #(
      .KEY_START (KEY_START),
      .KEY_END   (KEY_END)
   ) u_keylock (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (bus_wdata),
      .cfg_open (cfg_open),
      .idx_q    (idx_q)
   );

   sio_cfg_ldbank #(
      .NUM_LD    (NUM_LD),
      .IDX_LDSEL (IDX_LDSEL),
      .IDX_BMSB  (IDX_BMSB),
      .IDX_BLSB  (IDX_BLSB)
   ) u_ldbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_open  (cfg_open),
      .dat_wr    (dat_wr),
      .idx       (idx_q),
      .wdata     (bus_wdata),
      .ld_sel_q  (ld_sel),
      .base_flat (ld_base_flat)
   );

   assign sel_base = ld_base_flat[{ld_sel, 4'b0000} +: 16];

   sio_cfg_rdpath #(
      .LD_W      (LD_W),
      .IDX_LDSEL (IDX_LDSEL),
      .IDX_ID    (IDX_ID),
      .IDX_REV   (IDX_REV),
      .IDX_BMSB  (IDX_BMSB),
      .IDX_BLSB  (IDX_BLSB),
      .CHIP_ID   (CHIP_ID),
      .CHIP_REV  (CHIP_REV),
      .READ_REG  (READ_REG)
   ) u_rdpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .addr     (bus_addr),
      .cfg_open (cfg_open),
      .idx      (idx_q),
      .ld_sel   (ld_sel),
      .sel_base (sel_base),
      .rdata    (bus_rdata)
   );

   p_reset_locked_r1: assert property (@(posedge clk)
      !rst_n |=> (!cfg_open && idx_q == 8'h00));

endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

   localparam int NLD = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_addr = 1'b0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [7:0]      bus_wdata = 8'h00;
   logic [7:0]      bus_rdata;
   logic [NLD*16-1:0] ld_base_flat;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sio_cfg_port #(.NUM_LD(NLD)) u_sio_cfg_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .ld_base_flat (ld_base_flat)
   );

   task automatic check(input string req, input logic [NLD*16-1:0] act,
                        input logic [NLD*16-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [7:0] exp_msb(input int k);
      return 8'(8'h11 + k * 8'h13);
   endfunction
   function automatic logic [7:0] exp_lsb(input int k);
      return 8'(8'h03 + k * 8'h29);
   endfunction
   function automatic logic [NLD*16-1:0] exp_flat();
      logic [NLD*16-1:0] f;
      for (int k = 0; k < NLD; k++) f[k*16 +: 16] = {exp_msb(k), exp_lsb(k)};
      return f;
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         summary();
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 rdata", 128'(bus_rdata), 128'(8'hFF));
      check("R1 bases", ld_base_flat, '0);
      rd(1'b1, v); check("R1 R2 data locked", 128'(v), 128'(8'hFF));
      rd(1'b0, v); check("R2 index locked", 128'(v), 128'(8'hFF));

      // R3: locked writes ignored
      wr(1'b0, 8'h60); wr(1'b1, 8'hAB);
      check("R3 base untouched", ld_base_flat, '0);
      for (int i = 0; i < 256; i++) begin
         if (i == 8'h55) continue;
         wr(1'b0, 8'(i));
         rd(1'b1, v);
         check("R3 stays locked", 128'(v), 128'(8'hFF));
      end

      // R4 unlock, R1 index reset value
      wr(1'b0, 8'h55);
      rd(1'b0, v); check("R4 R1 index after unlock", 128'(v), 128'(8'h00));

      // R6 ID and revision, read-only
      wr(1'b0, 8'h20); rd(1'b1, v); check("R6 id", 128'(v), 128'(8'h7A));
      wr(1'b1, 8'h00); rd(1'b1, v); check("R6 id read-only", 128'(v), 128'(8'h7A));
      wr(1'b0, 8'h21); rd(1'b1, v); check("R6 rev", 128'(v), 128'(8'h01));
      wr(1'b1, 8'hC3); rd(1'b1, v); check("R6 rev read-only", 128'(v), 128'(8'h01));

      // R8 program every bank
      for (int k = 0; k < NLD; k++) begin
         wr(1'b0, 8'h07); wr(1'b1, 8'(k));
         wr(1'b0, 8'h60); wr(1'b1, exp_msb(k));
         wr(1'b0, 8'h61); wr(1'b1, exp_lsb(k));
      end
      check("R8 base outputs", ld_base_flat, exp_flat());
      for (int k = NLD - 1; k >= 0; k--) begin
         wr(1'b0, 8'h07); wr(1'b1, 8'(k));
         rd(1'b1, v); check("R7 select readback", 128'(v), 128'(k));
         wr(1'b0, 8'h60); rd(1'b1, v); check("R8 msb readback", 128'(v), 128'(exp_msb(k)));
         wr(1'b0, 8'h61); rd(1'b1, v); check("R8 lsb readback", 128'(v), 128'(exp_lsb(k)));
      end

      // R7 truncation: 0xFD keeps low 3 bits = 5
      wr(1'b0, 8'h07); wr(1'b1, 8'hFD);
      rd(1'b1, v); check("R7 truncated select", 128'(v), 128'(8'h05));

      // R5 R9 sweep of every index while unlocked
      for (int i = 0; i < 256; i++) begin
         if (i == 8'hAA) continue;
         wr(1'b0, 8'(i));
         rd(1'b0, v); check("R5 index readback", 128'(v), 128'(i));
         case (i)
            8'h20:   e = 8'h7A;
            8'h21:   e = 8'h01;
            8'h07:   e = 8'h05;
            8'h60:   e = exp_msb(5);
            8'h61:   e = exp_lsb(5);
            default: e = 8'h00;
         endcase
         if (e == 8'h00) wr(1'b1, 8'hFF);
         rd(1'b1, v); check("R9 data by index", 128'(v), 128'(e));
      end
      check("R9 bases after sweep", ld_base_flat, exp_flat());

      // R10 hold between reads
      wr(1'b0, 8'h20); rd(1'b1, v);
      wr(1'b0, 8'h61);
      repeat (4) @(negedge clk);
      check("R10 hold", 128'(bus_rdata), 128'(8'h7A));

      // R4 relock, R11 retention
      wr(1'b0, 8'hAA);
      rd(1'b1, v); check("R4 relocked", 128'(v), 128'(8'hFF));
      wr(1'b1, 8'h99);
      check("R11 bases kept while locked", ld_base_flat, exp_flat());
      wr(1'b0, 8'h55);
      wr(1'b0, 8'h07); rd(1'b1, v); check("R11 select kept", 128'(v), 128'(8'h05));
      wr(1'b1, 8'h03);
      wr(1'b0, 8'h60); rd(1'b1, v); check("R11 msb kept", 128'(v), 128'(exp_msb(3)));

      finished = 1'b1;
      summary();
   end

endmodule